// File: doc/BRIEF.md
# Fetch Target Queue

The fetch target queue keeps one record per fetch packet: the packet's fetch PC and the branch prediction metadata that went with it. The fetch side pushes records in through a valid/ready port. Each accepted push returns the slot index it was written to, and that index travels with the packet's micro-ops as a tag. Execution stages can look up any live slot by that tag to recover the PC, so the lookup is not limited to the oldest record.

Records leave from the oldest end only when the reorder buffer reports that the packet has committed. This happens one record per cycle at most. When the back end detects a misprediction, it names the slot of the mispredicting packet. The queue then drops every record younger than that slot in a single cycle by pulling its write pointer back to the next slot.

Back-pressure works as follows. A push is taken on a clock edge where both `enq_valid` and `enq_ready` are high. `enq_ready` is low while the queue is full and in any cycle that carries a redirect. The fetch side must hold its record until the push is taken. Commit and redirect are plain single-cycle strobes.

Top module: `fetch_target_queue`

## Requirements
- R1: After reset the queue is empty (`empty`=1), `enq_ready` is 1, `enq_idx` is 0, and `rd_live` is 0 for every index.
- R2: A push taken at a clock edge stores `enq_pc` and `enq_meta` in slot `enq_idx`. After each taken push, `enq_idx` advances by one modulo DEPTH.
- R3: After DEPTH pushes with no commits, `enq_ready` is 0. A push offered while full is not taken: no slot changes and `enq_idx` holds.
- R4: `rd_pc` and `rd_meta` show the contents of slot `rd_idx` in the same cycle. `rd_live` is 1 exactly when `rd_idx` lies among the occupied slots, counted from the oldest.
- R5: A `commit_valid` pulse on a non-empty queue frees the oldest slot at the next edge. On an empty queue it has no effect.
- R6: A `redir_valid` pulse with `redir_idx` naming a live slot keeps that slot and all older slots. All younger slots stop being live after the edge, and `enq_idx` becomes `redir_idx`+1 modulo DEPTH.
- R7: In a cycle with `redir_valid`=1, `enq_ready` is 0, so a push offered in that cycle is not taken.
- R8: Slot indices wrap modulo DEPTH. A full queue whose oldest slot is not slot 0 still reports full, and never reports empty.
- R9: A commit and a taken push in the same cycle leave the occupancy unchanged. The oldest slot is freed and the new record is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Fetch offers a record |
| enq_ready | output | 1 | Queue can take a record this cycle |
| enq_pc | input | PC_W | Fetch PC of the packet |
| enq_meta | input | META_W | Prediction metadata of the packet |
| enq_idx | output | log2(DEPTH) | Slot the next taken push writes |
| rd_idx | input | log2(DEPTH) | Slot to look up |
| rd_pc | output | PC_W | PC stored in slot `rd_idx` |
| rd_meta | output | META_W | Metadata stored in slot `rd_idx` |
| rd_live | output | 1 | Slot `rd_idx` is occupied |
| commit_valid | input | 1 | Oldest packet committed |
| redir_valid | input | 1 | Misprediction redirect |
| redir_idx | input | log2(DEPTH) | Slot of the mispredicting packet |
| empty | output | 1 | No slot occupied |

## Verification
`enq_ready`, `enq_idx`, `rd_pc`, `rd_meta` and `rd_live` are combinational from the current pointers and inputs. They are valid within the same cycle as the stimulus. The bench reads them 1 ns after applying inputs, which is well before the next rising edge. Pushes, commits and redirects change the pointers at the first rising edge after they are offered. Their effect is therefore checked in the cycle after that edge, with inputs applied 2 ns past the edge. A bench model of the head and tail counters supplies every expected index and liveness value.

// File: rtl/ftq_pkg.sv
`timescale 1ns/1ps
package ftq_pkg;
  localparam int unsigned FTQ_DEPTH_DEF  = 8;
  localparam int unsigned FTQ_PC_W_DEF   = 32;
  localparam int unsigned FTQ_META_W_DEF = 8;
endpackage

// File: rtl/ftq_ptrs.sv
`timescale 1ns/1ps
module ftq_ptrs #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic          commit_valid,
  input  logic          redir_valid,
  input  logic [IW-1:0] redir_idx,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic          full,
  output logic          empty,
  output logic          enq_fire
);
  logic [PW-1:0] head_q, tail_q, head_d, tail_d;
  logic [IW-1:0] gap;
  logic          deq_fire;

  assign empty    = (head_q == tail_q);
  assign full     = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
  assign enq_fire = enq_valid && !full && !redir_valid;
  assign deq_fire = commit_valid && !empty;
  assign gap      = redir_idx - head_q[IW-1:0];

  always_comb begin
    head_d = head_q + PW'(deq_fire);
    if (redir_valid) tail_d = head_q + {1'b0, gap} + PW'(1);
    else             tail_d = tail_q + PW'(enq_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
endmodule

// File: rtl/ftq_store.sv
`timescale 1ns/1ps
module ftq_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WIDTH  = 40,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/fetch_target_queue.sv
`timescale 1ns/1ps
module fetch_target_queue
  import ftq_pkg::*;
#(
  parameter int unsigned DEPTH  = FTQ_DEPTH_DEF,
  parameter int unsigned PC_W   = FTQ_PC_W_DEF,
  parameter int unsigned META_W = FTQ_META_W_DEF,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1,
  localparam int unsigned EW = PC_W + META_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [PC_W-1:0]   enq_pc,
  input  logic [META_W-1:0] enq_meta,
  output logic [IW-1:0]     enq_idx,
  input  logic [IW-1:0]     rd_idx,
  output logic [PC_W-1:0]   rd_pc,
  output logic [META_W-1:0] rd_meta,
  output logic              rd_live,
  input  logic              commit_valid,
  input  logic              redir_valid,
  input  logic [IW-1:0]     redir_idx,
  output logic              empty
);
  logic [PW-1:0] head_ptr, tail_ptr, used;
  logic [IW-1:0] rd_off;
  logic          full, enq_fire;
  logic [EW-1:0] rd_word;

  ftq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid),
    .commit_valid(commit_valid), .redir_valid(redir_valid), .redir_idx(redir_idx),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .full(full), .empty(empty),
    .enq_fire(enq_fire)
  );

  ftq_store #(.DEPTH(DEPTH), .WIDTH(EW)) u_store (
    .clk(clk), .wr_en(enq_fire), .wr_idx(tail_ptr[IW-1:0]),
    .wr_data({enq_pc, enq_meta}), .rd_idx(rd_idx), .rd_data(rd_word)
  );

  assign enq_ready = !full && !redir_valid;
  assign enq_idx   = tail_ptr[IW-1:0];
  assign used      = tail_ptr - head_ptr;
  assign rd_off    = rd_idx - head_ptr[IW-1:0];
  assign rd_live   = ({1'b0, rd_off} < used);
  assign rd_pc     = rd_word[EW-1:META_W];
  assign rd_meta   = rd_word[META_W-1:0];
endmodule

// File: rtl/ftq_checker.sv
`timescale 1ns/1ps
module ftq_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic [IW-1:0] enq_idx,
  input logic          rd_live,
  input logic          commit_valid,
  input logic          redir_valid,
  input logic [IW-1:0] redir_idx,
  input logic          empty,
  input logic          full,
  input logic [PW-1:0] head_ptr,
  input logic [PW-1:0] tail_ptr
);
  a_r2_enq_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready) |=> enq_idx == $past(enq_idx) + IW'(1));
  a_r3_no_enq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !enq_ready);
  a_r4_empty_none_live: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_live);
  a_r5_commit_frees_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !empty) |=> head_ptr == $past(head_ptr) + PW'(1));
  a_r6_tail_after_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> enq_idx == $past(redir_idx) + IW'(1));
  a_r7_redirect_blocks_enq: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !enq_ready);
  a_r8_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_ptr - head_ptr) <= PW'(DEPTH));
endmodule

bind fetch_target_queue ftq_checker #(.DEPTH(DEPTH)) i_ftq_checker (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .enq_idx(enq_idx), .rd_live(rd_live), .commit_valid(commit_valid),
  .redir_valid(redir_valid), .redir_idx(redir_idx), .empty(empty),
  .full(full), .head_ptr(head_ptr), .tail_ptr(tail_ptr)
);

// File: tb/test_fetch_target_queue.sv
`timescale 1ns/1ps
module test_fetch_target_queue;
  localparam int D = 8;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, commit_valid = 0, redir_valid = 0;
  logic [31:0] enq_pc = 0;
  logic [7:0]  enq_meta = 0;
  logic [2:0]  rd_idx = 0, redir_idx = 0;
  logic        enq_ready, rd_live, empty;
  logic [2:0]  enq_idx;
  logic [31:0] rd_pc;
  logic [7:0]  rd_meta;

  int checks = 0, errors = 0;
  logic [31:0] mpc [D];
  logic [7:0]  mmeta [D];
  int mh = 0, mt = 0;

  always #4 clk = ~clk;

  fetch_target_queue i_fetch_target_queue (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_pc(enq_pc), .enq_meta(enq_meta), .enq_idx(enq_idx), .rd_idx(rd_idx),
    .rd_pc(rd_pc), .rd_meta(rd_meta), .rd_live(rd_live),
    .commit_valid(commit_valid), .redir_valid(redir_valid),
    .redir_idx(redir_idx), .empty(empty)
  );

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  function automatic bit m_live(int idx);
    return ((idx - (mh % D) + D) % D) < (mt - mh);
  endfunction

  task automatic look(int idx, string req);
    rd_idx = 3'(idx); #1;
    chk({req, " live"}, rd_live, m_live(idx));
    if (m_live(idx)) begin
      chk({req, " pc"}, rd_pc, mpc[idx]);
      chk({req, " meta"}, rd_meta, mmeta[idx]);
    end
  endtask

  task automatic push(logic [31:0] pc, logic [7:0] meta, string req);
    bit acc;
    enq_valid = 1; enq_pc = pc; enq_meta = meta; #1;
    acc = (mt - mh) < D;
    chk({req, " ready"}, enq_ready, acc);
    chk({req, " idx"}, enq_idx, mt % D);
    tick;
    if (acc) begin mpc[mt % D] = pc; mmeta[mt % D] = meta; mt++; end
    enq_valid = 0;
  endtask

  task automatic pop;
    commit_valid = 1; tick; commit_valid = 0;
    if (mt > mh) mh++;
  endtask

  task automatic redirect(int idx, bit with_enq);
    redir_valid = 1; redir_idx = 3'(idx); enq_valid = with_enq; enq_pc = 32'hDEAD; #1;
    chk("R7 ready low on redirect", enq_ready, 0);
    tick;
    redir_valid = 0; enq_valid = 0;
    mt = mh + ((idx - (mh % D) + D) % D) + 1;
  endtask

  task automatic t_reset;
    chk("R1 empty", empty, 1);
    chk("R1 ready", enq_ready, 1);
    chk("R1 idx", enq_idx, 0);
    for (int i = 0; i < D; i++) begin rd_idx = 3'(i); #1; chk("R1 none live", rd_live, 0); end
  endtask

  task automatic t_fill;
    for (int i = 0; i < D; i++) push(32'h1000 + 32'(i) * 32'h40, 8'(8'hA0 + i), "R2 fill");
    #1 chk("R3 ready low when full", enq_ready, 0);
    chk("R3 not empty", empty, 0);
    push(32'hBAD0, 8'hEE, "R3 push while full");
    chk("R3 idx holds", enq_idx, 0);
    for (int i = 0; i < D; i++) look(i, "R4 read after fill");
  endtask

  task automatic t_commit_wrap;
    for (int i = 0; i < 3; i++) pop;
    for (int i = 0; i < D; i++) look(i, "R5 after commits");
    for (int i = 0; i < 3; i++) push(32'h2000 + 32'(i), 8'(8'h50 + i), "R8 wrap push");
    #1 chk("R8 full at offset head", enq_ready, 0);
    chk("R8 not empty", empty, 0);
    for (int i = 0; i < D; i++) look(i, "R8 read wrapped");
  endtask

  task automatic t_redirect;
    redirect(5, 0);
    #1 chk("R6 enq idx", enq_idx, 6);
    for (int i = 0; i < D; i++) look(i, "R6 live after redirect");
    redirect(4, 1);
    #1 chk("R7 push dropped idx", enq_idx, 5);
    look(5, "R7 slot not written");
    look(4, "R7 kept slot");
  endtask

  task automatic t_drain;
    while (mt > mh) pop;
    #1 chk("R5 drained empty", empty, 1);
    pop;
    #1 chk("R5 commit on empty", empty, 1);
    chk("R5 idx unchanged", enq_idx, mt % D);
    push(32'h3000, 8'h11, "R9 setup");
    commit_valid = 1;
    push(32'h3004, 8'h12, "R9 push with commit");
    commit_valid = 0; mh++;
    #1 chk("R9 not empty", empty, 0);
    for (int i = 0; i < D; i++) look(i, "R9 one live");
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1; #1;
    t_reset;
    t_fill;
    t_commit_wrap;
    t_redirect;
    t_drain;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule